// File: doc/BRIEF.md
# Relative-Distance Torus Router

This block sits in each node of a three-dimensional torus of processing nodes and turns one remote-access request into a concrete route. Every node gets the same request at the same moment. Each node applies it to its own X/Y/Z position, so the whole machine moves data by one uniform relative distance at once.

In point-to-point mode, a request carries a signed offset per axis. The block returns three things:
- the destination coordinates, wrapped at the machine size on each axis;
- one link-enable bit per axis with a nonzero offset, so that multi-axis moves run on parallel per-axis paths;
- a local flag when nothing has to move.

In broadcast mode, the request names a source node and spans one of three shapes:
- a line along one axis;
- a plane normal to one axis;
- the whole machine.

The block then reports which axes are used and whether this node is a receiver.

All results are registered and appear one clock after the request. Machine sizes are inputs, so one netlist serves any partition up to 2^CW nodes per axis. A 2x2x2 board cube is simply sizes of 2.

Top module: `rel_dist_router`

## Requirements
- R1: After reset is asserted, `valid_o`, `link_en_o`, `local_o` and `rx_en_o` are all 0.
- R2: A request sampled with `req_valid_i`=1 on a rising edge gives `valid_o`=1 after that edge. An edge with `req_valid_i`=0 gives `valid_o`=0.
- R3: In mode 0 (point-to-point), each destination coordinate equals (own + offset) mod size for that axis. Wraparound applies in both directions, for offsets from -(size-1) to size-1 and own coordinates below size.
- R4: In mode 0, the link enables are bit 0 = X, bit 1 = Y and bit 2 = Z. Each bit is 1 exactly when that axis offset is nonzero.
- R5: `local_o` is 1 exactly when the mode is 0 and all three offsets are zero.
- R6: In mode 1 (line), `link_en_o` has only the bit of the selected axis set. Selector 0 = X, 1 = Y, 2 = Z, and 3 acts as X. `rx_en_o` is 1 exactly when the node's own coordinates equal the source coordinates on both other axes.
- R7: In mode 2 (plane), `link_en_o` has the two bits other than the normal axis set, using the same selector coding. `rx_en_o` is 1 exactly when the own coordinate equals the source coordinate on the normal axis.
- R8: In mode 3 (full machine), `link_en_o` = 3'b111 and `rx_en_o` = 1.
- R9: In modes 1 to 3, the destination outputs carry the source coordinates and `local_o` is 0.
- R10: In mode 0, `rx_en_o` is 1.
- R11: An edge with `req_valid_i`=0 leaves the destination, link, local and receive outputs unchanged, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| mode_i | input | 2 | 0 point-to-point, 1 line, 2 plane, 3 full |
| axis_sel_i | input | 2 | Line axis or plane normal (0 X, 1 Y, 2 Z, 3 as X) |
| off_x_i | input | CW+1 | Signed X offset |
| off_y_i | input | CW+1 | Signed Y offset |
| off_z_i | input | CW+1 | Signed Z offset |
| own_x_i | input | CW | This node's X coordinate |
| own_y_i | input | CW | This node's Y coordinate |
| own_z_i | input | CW | This node's Z coordinate |
| src_x_i | input | CW | Broadcast source X |
| src_y_i | input | CW | Broadcast source Y |
| src_z_i | input | CW | Broadcast source Z |
| size_x_i | input | CW+1 | Machine size along X |
| size_y_i | input | CW+1 | Machine size along Y |
| size_z_i | input | CW+1 | Machine size along Z |
| valid_o | output | 1 | Result valid |
| dst_x_o | output | CW | Destination or source X |
| dst_y_o | output | CW | Destination or source Y |
| dst_z_o | output | CW | Destination or source Z |
| link_en_o | output | 3 | Per-axis path enables (bit 0 X) |
| local_o | output | 1 | Zero-distance access, no link |
| rx_en_o | output | 1 | This node receives |

## Verification
Every result is due exactly one rising edge after the request edge, because a single register stage follows the arithmetic. The bench drives inputs on the falling edge and compares all outputs on the next falling edge, half a cycle after they settle. It sweeps every own coordinate and every legal offset in a 4x3x2 machine, and every own/source/mode/selector combination in a 2x2x2 cube. The hold rule is checked by an idle edge with changed inputs, followed by a look at the outputs before the next request.

// File: rtl/rdr_pkg.sv
package rdr_pkg;
  localparam int unsigned NAXES = 3;
  typedef enum logic [1:0] {
    MODE_P2P   = 2'd0,
    MODE_LINE  = 2'd1,
    MODE_PLANE = 2'd2,
    MODE_FULL  = 2'd3
  } bc_mode_e;
endpackage

// File: rtl/rdr_axis_step.sv
module rdr_axis_step #(
  parameter int unsigned CW = 4
) (
  input  logic [CW-1:0]      own_i,
  input  logic signed [CW:0] off_i,
  input  logic [CW:0]        size_i,
  output logic [CW-1:0]      dst_o,
  output logic               move_o
);
  localparam int unsigned SW = CW + 2;
  logic signed [SW-1:0] sum_s, size_s, wrap_s;

  always_comb begin
    sum_s  = $signed({2'b00, own_i}) + $signed({off_i[CW], off_i});
    size_s = $signed({1'b0, size_i});
    if (sum_s < 0)            wrap_s = sum_s + size_s;
    else if (sum_s >= size_s) wrap_s = sum_s - size_s;
    else                      wrap_s = sum_s;
  end

  assign dst_o  = wrap_s[CW-1:0];
  assign move_o = (off_i != '0);
endmodule

// File: rtl/rdr_span_decode.sv
module rdr_span_decode
  import rdr_pkg::*;
(
  input  bc_mode_e                 mode_i,
  input  logic [1:0]               axis_sel_i,
  output logic [NAXES-1:0]         span_o
);
  logic [NAXES-1:0] sel_oh;

  always_comb begin
    unique case (axis_sel_i)
      2'd1:    sel_oh = 3'b010;
      2'd2:    sel_oh = 3'b100;
      default: sel_oh = 3'b001;
    endcase
    unique case (mode_i)
      MODE_LINE:  span_o = sel_oh;
      MODE_PLANE: span_o = ~sel_oh;
      MODE_FULL:  span_o = 3'b111;
      default:    span_o = 3'b000;
    endcase
  end
endmodule

// File: rtl/rdr_rx_match.sv
module rdr_rx_match
  import rdr_pkg::*;
#(
  parameter int unsigned CW = 4
) (
  input  logic [NAXES-1:0][CW-1:0] own_i,
  input  logic [NAXES-1:0][CW-1:0] src_i,
  input  logic [NAXES-1:0]         span_i,
  output logic                     rx_o
);
  logic [NAXES-1:0] eq;

  for (genvar a = 0; a < NAXES; a++) begin : g_eq
    assign eq[a] = (own_i[a] == src_i[a]);
  end

  // axes not spanned must match the source
  assign rx_o = &(span_i | eq);
endmodule

// File: rtl/rel_dist_router.sv
module rel_dist_router
  import rdr_pkg::*;
#(
  parameter int unsigned CW = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        mode_i,
  input  logic [1:0]        axis_sel_i,
  input  logic signed [CW:0] off_x_i,
  input  logic signed [CW:0] off_y_i,
  input  logic signed [CW:0] off_z_i,
  input  logic [CW-1:0]     own_x_i,
  input  logic [CW-1:0]     own_y_i,
  input  logic [CW-1:0]     own_z_i,
  input  logic [CW-1:0]     src_x_i,
  input  logic [CW-1:0]     src_y_i,
  input  logic [CW-1:0]     src_z_i,
  input  logic [CW:0]       size_x_i,
  input  logic [CW:0]       size_y_i,
  input  logic [CW:0]       size_z_i,
  output logic              valid_o,
  output logic [CW-1:0]     dst_x_o,
  output logic [CW-1:0]     dst_y_o,
  output logic [CW-1:0]     dst_z_o,
  output logic [2:0]        link_en_o,
  output logic              local_o,
  output logic              rx_en_o
);
  bc_mode_e mode;
  assign mode = bc_mode_e'(mode_i);

  logic [NAXES-1:0][CW-1:0] own_a, src_a, p2p_dst;
  logic [NAXES-1:0][CW:0]   off_a, size_a;
  logic [NAXES-1:0]         move, span;
  logic                     bc_rx;

  assign own_a  = {own_z_i, own_y_i, own_x_i};
  assign src_a  = {src_z_i, src_y_i, src_x_i};
  assign off_a  = {off_z_i, off_y_i, off_x_i};
  assign size_a = {size_z_i, size_y_i, size_x_i};

  for (genvar a = 0; a < NAXES; a++) begin : g_axis
    rdr_axis_step #(.CW(CW)) u_step (
      .own_i  (own_a[a]),
      .off_i  ($signed(off_a[a])),
      .size_i (size_a[a]),
      .dst_o  (p2p_dst[a]),
      .move_o (move[a])
    );
  end

  rdr_span_decode u_span (
    .mode_i     (mode),
    .axis_sel_i (axis_sel_i),
    .span_o     (span)
  );

  rdr_rx_match #(.CW(CW)) u_rx (
    .own_i  (own_a),
    .src_i  (src_a),
    .span_i (span),
    .rx_o   (bc_rx)
  );

  logic                     is_p2p;
  logic [NAXES-1:0][CW-1:0] dst_d;
  logic [NAXES-1:0]         link_d;
  logic                     local_d, rx_d;

  always_comb begin
    is_p2p  = (mode == MODE_P2P);
    dst_d   = is_p2p ? p2p_dst : src_a;
    link_d  = is_p2p ? move : span;
    local_d = is_p2p && (move == '0);
    rx_d    = is_p2p ? 1'b1 : bc_rx;
  end

  logic [NAXES-1:0][CW-1:0] dst_q;
  logic [NAXES-1:0]         link_q;
  logic                     valid_q, local_q, rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      dst_q   <= '0;
      link_q  <= '0;
      local_q <= 1'b0;
      rx_q    <= 1'b0;
    end else begin
      valid_q <= req_valid_i;
      if (req_valid_i) begin
        dst_q   <= dst_d;
        link_q  <= link_d;
        local_q <= local_d;
        rx_q    <= rx_d;
      end
    end
  end

  assign valid_o   = valid_q;
  assign dst_x_o   = dst_q[0];
  assign dst_y_o   = dst_q[1];
  assign dst_z_o   = dst_q[2];
  assign link_en_o = link_q;
  assign local_o   = local_q;
  assign rx_en_o   = rx_q;
endmodule

// File: rtl/rdr_router_chk.sv
module rdr_router_chk #(
  parameter int unsigned CW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic [1:0]    mode_i,
  input logic [CW:0]   size_x_i,
  input logic [CW:0]   size_y_i,
  input logic [CW:0]   size_z_i,
  input logic          valid_o,
  input logic [CW-1:0] dst_x_o,
  input logic [CW-1:0] dst_y_o,
  input logic [CW-1:0] dst_z_o,
  input logic [2:0]    link_en_o,
  input logic          local_o,
  input logic          rx_en_o
);
  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && link_en_o == 3'b0 && !local_o && !rx_en_o)); // R1

  AST_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> valid_o); // R2

  AST_DST_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && mode_i == 2'd0) |=>
      (dst_x_o < $past(size_x_i) && dst_y_o < $past(size_y_i) && dst_z_o < $past(size_z_i))); // R3

  AST_LOCAL_NO_LINK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && local_o) |-> link_en_o == 3'b0); // R5

  AST_LINE_ONE_LINK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && mode_i == 2'd1) |=> $countones(link_en_o) == 1); // R6

  AST_PLANE_TWO_LINKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && mode_i == 2'd2) |=> $countones(link_en_o) == 2); // R7

  AST_FULL_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && mode_i == 2'd3) |=> (rx_en_o && link_en_o == 3'b111)); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_valid_i && valid_o) |=> ($stable(link_en_o) && $stable(dst_x_o) && $stable(rx_en_o))); // R11
endmodule

bind rel_dist_router rdr_router_chk #(.CW(CW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .mode_i      (mode_i),
  .size_x_i    (size_x_i),
  .size_y_i    (size_y_i),
  .size_z_i    (size_z_i),
  .valid_o     (valid_o),
  .dst_x_o     (dst_x_o),
  .dst_y_o     (dst_y_o),
  .dst_z_o     (dst_z_o),
  .link_en_o   (link_en_o),
  .local_o     (local_o),
  .rx_en_o     (rx_en_o)
);

// File: tb/rel_dist_router_tb.sv
module rel_dist_router_tb;
  localparam int CW = 3;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] mode = 2'd0, sel = 2'd0;
  logic signed [CW:0] ox = '0, oy = '0, oz = '0;
  logic [CW-1:0] wx = '0, wy = '0, wz = '0, sx = '0, sy = '0, sz = '0;
  logic [CW:0] nx = 4'd4, ny = 4'd3, nz = 4'd2;
  logic valid_o, local_o, rx_en_o;
  logic [CW-1:0] dx, dy, dz;
  logic [2:0] link;

  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  rel_dist_router #(.CW(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .mode_i(mode),
    .axis_sel_i(sel), .off_x_i(ox), .off_y_i(oy), .off_z_i(oz),
    .own_x_i(wx), .own_y_i(wy), .own_z_i(wz),
    .src_x_i(sx), .src_y_i(sy), .src_z_i(sz),
    .size_x_i(nx), .size_y_i(ny), .size_z_i(nz),
    .valid_o(valid_o), .dst_x_o(dx), .dst_y_o(dy), .dst_z_o(dz),
    .link_en_o(link), .local_o(local_o), .rx_en_o(rx_en_o)
  );

  task automatic check(input string tag, input logic [CW-1:0] ex, ey, ez,
                       input logic [2:0] el, input logic eloc, erx, ev);
    n_run++;
    if (valid_o !== ev || dx !== ex || dy !== ey || dz !== ez ||
        link !== el || local_o !== eloc || rx_en_o !== erx) begin
      n_fail++;
      $display("FAIL %s: got v=%0b d=%0d,%0d,%0d l=%b loc=%0b rx=%0b exp v=%0b d=%0d,%0d,%0d l=%b loc=%0b rx=%0b",
               tag, valid_o, dx, dy, dz, link, local_o, rx_en_o,
               ev, ex, ey, ez, el, eloc, erx);
    end
  endtask

  function automatic int wrapc(input int own, input int off, input int n);
    return ((own + off) % n + n) % n;
  endfunction

  function automatic logic [2:0] sel_oh(input int s);
    return (s == 1) ? 3'b010 : (s == 2) ? 3'b100 : 3'b001;
  endfunction

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [CW-1:0] hx, hy, hz;
    logic [2:0] hl;
    logic hloc, hrx;
    repeat (2) @(negedge clk);
    n_run++;
    if (valid_o !== 1'b0 || link !== 3'b0 || local_o !== 1'b0 || rx_en_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: got v=%0b l=%b loc=%0b rx=%0b exp all zero", valid_o, link, local_o, rx_en_o);
    end
    rst_ni = 1'b1;

    // point-to-point sweep, 4x3x2 machine
    nx = 4; ny = 3; nz = 2;
    for (int x = 0; x < 4; x++) for (int y = 0; y < 3; y++) for (int z = 0; z < 2; z++)
      for (int a = -3; a <= 3; a++) for (int b = -2; b <= 2; b++) for (int c = -1; c <= 1; c++) begin
        @(negedge clk);
        req_valid = 1; mode = 2'd0; sel = 2'(a & 3);
        wx = x[CW-1:0]; wy = y[CW-1:0]; wz = z[CW-1:0];
        ox = a[CW:0]; oy = b[CW:0]; oz = c[CW:0];
        sx = 3'(x + 1); sy = 3'(b & 7); sz = 3'd5;
        @(negedge clk);
        check("R2/R3/R4/R5/R10",
              3'(wrapc(x, a, 4)), 3'(wrapc(y, b, 3)), 3'(wrapc(z, c, 2)),
              {c != 0, b != 0, a != 0}, (a == 0 && b == 0 && c == 0), 1'b1, 1'b1);
      end

    // R2: idle edge drops valid; R11: held outputs despite changed inputs
    hx = dx; hy = dy; hz = dz; hl = link; hloc = local_o; hrx = rx_en_o;
    req_valid = 0; mode = 2'd3; ox = 1; oy = 1; oz = 1; sx = 2; sy = 2; sz = 1;
    @(negedge clk);
    check("R2/R11 idle", hx, hy, hz, hl, hloc, hrx, 1'b0);
    @(negedge clk);
    check("R11 idle hold", hx, hy, hz, hl, hloc, hrx, 1'b0);

    // broadcast sweep, 2x2x2 cube
    nx = 2; ny = 2; nz = 2;
    for (int own = 0; own < 8; own++) for (int src = 0; src < 8; src++)
      for (int m = 1; m <= 3; m++) for (int s = 0; s < 4; s++) begin
        logic [2:0] eq, span;
        logic erx;
        @(negedge clk);
        req_valid = 1; mode = m[1:0]; sel = s[1:0];
        wx = 3'(own & 1); wy = 3'((own >> 1) & 1); wz = 3'((own >> 2) & 1);
        sx = 3'(src & 1); sy = 3'((src >> 1) & 1); sz = 3'((src >> 2) & 1);
        ox = 0; oy = 0; oz = 0;
        eq = {wz == sz, wy == sy, wx == sx};
        span = (m == 1) ? sel_oh(s) : (m == 2) ? ~sel_oh(s) : 3'b111;
        erx = &(span | eq);
        @(negedge clk);
        if (m == 1)      check("R6/R9 line",  sx, sy, sz, span, 1'b0, erx, 1'b1);
        else if (m == 2) check("R7/R9 plane", sx, sy, sz, span, 1'b0, erx, 1'b1);
        else             check("R8/R9 full",  sx, sy, sz, span, 1'b0, 1'b1, 1'b1);
      end

    // cube neighbour corners with wrap: offsets -1 and +1 land on the same node
    for (int own = 0; own < 8; own++) begin
      @(negedge clk);
      req_valid = 1; mode = 2'd0;
      wx = 3'(own & 1); wy = 3'((own >> 1) & 1); wz = 3'((own >> 2) & 1);
      ox = -1; oy = 1; oz = 0;
      @(negedge clk);
      check("R3/R4 cube wrap", 3'(1 - (own & 1)), 3'(1 - ((own >> 1) & 1)),
            3'((own >> 2) & 1), 3'b011, 1'b0, 1'b1, 1'b1);
    end

    req_valid = 0;
    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule